// File: doc/BRIEF.md
# Tracking Gradient Accumulator

This block runs one iteration of a sum-of-squared-differences feature tracker. Over a rectangular window it takes two raster-ordered pixel streams at once: a reference (template) pixel and the pixel at the same place in a current image that has already been warped. For each interior position it forms a temporal difference and two central-difference spatial gradients of the reference. It adds the five products that a two-unknown motion solve needs into wide signed fixed-point accumulators. A host processor reads the sums after the done pulse and carries out the small matrix inversion itself.

The gradients come from a three-row store of reference pixels that is refilled on every run. No gradient image is fetched and none is kept. The window width and height are taken from the dimension inputs on a start pulse, so the run length is set for each task. Pixels enter through a valid/ready handshake, and the producer may pause between pixels at any point.

Top module: `gsa_tracker`

## Requirements
- R1: While reset is asserted and directly after it, `in_ready` and `done` are low and all five sums read zero.
- R2: A start pulse captures `win_w`/`win_h` and sets all five sums to zero on the same clock edge. If both dimensions are nonzero, `in_ready` is high in the following cycle.
- R3: `in_ready` is low in any cycle where `start` is high and whenever no window is open. A pixel is taken only in a cycle where both `in_valid` and `in_ready` are high.
- R4: The temporal term at position (x,y) is It = cur(x,y) − ref(x,y), as a signed value.
- R5: The horizontal gradient is Ix = ref(x+1,y) − ref(x−1,y). The vertical gradient is Iy = ref(x,y+1) − ref(x,y−1). Here y grows downward in raster order.
- R6: Only positions with 1 ≤ x ≤ W−2 and 1 ≤ y ≤ H−2 contribute. The outputs are the signed sums `sum_xx`=ΣIx², `sum_xy`=ΣIx·Iy, `sum_yy`=ΣIy², `sum_xt`=ΣIx·It and `sum_yt`=ΣIy·It.
- R7: `in_ready` goes low in the cycle after the last pixel of the window is taken. `done` is high for exactly one cycle, two clock edges after the edge on which the last pixel was taken.
- R8: After `done`, the sums do not change until the next start pulse.
- R9: Idle cycles (with `in_valid` low) inserted anywhere in the stream do not change any sum.
- R10: If a start pulse carries a width or height of zero, no window opens: `in_ready` stays low, the sums are zero and `done` pulses on the next edge.
- R11: A width or height above MAX_DIM (64) is treated as MAX_DIM.
- R12: A start pulse while a window is open abandons that window. Its pixels still in flight add nothing, and only the new window's pixels form the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens a window: captures dimensions and clears sums |
| win_w | input | 7 | Window width in pixels |
| win_h | input | 7 | Window height in pixels |
| in_valid | input | 1 | Pixel pair present |
| in_ready | output | 1 | Block accepts a pixel pair |
| ref_px | input | 8 | Reference pixel, unsigned |
| cur_px | input | 8 | Warped current pixel, unsigned |
| done | output | 1 | One-cycle pulse: sums are final |
| sum_xx | output | 40 | ΣIx², signed |
| sum_xy | output | 40 | ΣIx·Iy, signed |
| sum_yy | output | 40 | ΣIy², signed |
| sum_xt | output | 40 | ΣIx·It, signed |
| sum_yt | output | 40 | ΣIy·It, signed |

## Verification
A start pulse can arrive in the same cycle as a pixel that the producer offers. It can also arrive while derivative products from the old window are still in the pipeline and have not yet been added. The bench provokes both cases by raising `start` in the middle of a window with `in_valid` held high. It judges the outcome on three points: `in_ready` must be low in that cycle, the sums must read zero after the edge, and the final sums must equal a model that sees only the new window's pixels. A separate run with zero-size windows makes the start pulse and the done pulse fall on adjacent edges.

// File: rtl/gsa_pkg.sv
package gsa_pkg;
  typedef enum logic [0:0] {
    WIN_IDLE = 1'b0,
    WIN_OPEN = 1'b1
  } win_state_e;

  localparam int unsigned N_SUMS = 5;
endpackage

// File: rtl/gsa_win_ctrl.sv
module gsa_win_ctrl
  import gsa_pkg::*;
#(
  parameter int unsigned MAX_DIM = 64,
  localparam int unsigned DIM_W = $clog2(MAX_DIM + 1),
  localparam int unsigned COL_W = $clog2(MAX_DIM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIM_W-1:0] w_in,
  input  logic [DIM_W-1:0] h_in,
  input  logic             in_valid,
  input  logic             tail_last,
  output logic             in_ready,
  output logic             accept,
  output logic             inner,
  output logic             last_px,
  output logic [COL_W-1:0] col,
  output logic             done
);
  win_state_e       state_q, state_n;
  logic [DIM_W-1:0] wid_q, wid_n, hgt_q, hgt_n;
  logic [COL_W-1:0] col_q, col_n, row_q, row_n;
  logic             s2_q, s2_n, done_q, done_n;
  logic [DIM_W-1:0] w_eff, h_eff;
  logic             empty, row_end;

  assign w_eff    = (w_in > DIM_W'(MAX_DIM)) ? DIM_W'(MAX_DIM) : w_in;
  assign h_eff    = (h_in > DIM_W'(MAX_DIM)) ? DIM_W'(MAX_DIM) : h_in;
  assign empty    = (w_eff == '0) || (h_eff == '0);
  assign in_ready = (state_q == WIN_OPEN) && !start;
  assign accept   = in_valid && in_ready;
  assign row_end  = DIM_W'(col_q) == (wid_q - 1'b1);
  assign last_px  = row_end && (DIM_W'(row_q) == (hgt_q - 1'b1));
  assign inner    = (col_q >= COL_W'(2)) && (row_q >= COL_W'(2));
  assign col      = col_q;
  assign done     = done_q;

  always_comb begin
    state_n = state_q;
    wid_n   = wid_q;
    hgt_n   = hgt_q;
    col_n   = col_q;
    row_n   = row_q;
    s2_n    = tail_last;
    done_n  = s2_q;
    if (start) begin
      wid_n   = w_eff;
      hgt_n   = h_eff;
      col_n   = '0;
      row_n   = '0;
      state_n = empty ? WIN_IDLE : WIN_OPEN;
      s2_n    = 1'b0;
      done_n  = empty;
    end else if (accept) begin
      if (last_px) begin
        state_n = WIN_IDLE;
        col_n   = '0;
        row_n   = '0;
      end else if (row_end) begin
        col_n = '0;
        row_n = row_q + 1'b1;
      end else begin
        col_n = col_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WIN_IDLE;
      wid_q   <= '0;
      hgt_q   <= '0;
      col_q   <= '0;
      row_q   <= '0;
      s2_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      wid_q   <= wid_n;
      hgt_q   <= hgt_n;
      col_q   <= col_n;
      row_q   <= row_n;
      s2_q    <= s2_n;
      done_q  <= done_n;
    end
  end

  p_ready_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && last_px) |=> !in_ready);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start) |=> !done_q);
  p_empty_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && empty) |=> (done_q && state_q == WIN_IDLE));
  p_col_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WIN_OPEN) |-> (DIM_W'(col_q) < wid_q && DIM_W'(row_q) < hgt_q));
endmodule

// File: rtl/gsa_line_taps.sv
module gsa_line_taps #(
  parameter int unsigned PIX_W   = 8,
  parameter int unsigned MAX_DIM = 64,
  localparam int unsigned COL_W  = $clog2(MAX_DIM),
  localparam int unsigned DER_W  = PIX_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    accept,
  input  logic [COL_W-1:0]        col,
  input  logic [PIX_W-1:0]        ref_px,
  input  logic [PIX_W-1:0]        cur_px,
  output logic signed [DER_W-1:0] gx,
  output logic signed [DER_W-1:0] gy,
  output logic signed [DER_W-1:0] gt
);
  // Row stores: previous reference row, the one before it, previous current row.
  logic [PIX_W-1:0] up1_mem [MAX_DIM];
  logic [PIX_W-1:0] up2_mem [MAX_DIM];
  logic [PIX_W-1:0] cu1_mem [MAX_DIM];
  logic [PIX_W-1:0] up1_rd, up2_rd, cu1_rd;
  // Column taps captured from the reads of the two preceding accepts.
  logic [PIX_W-1:0] a1_q, a2_q, b1_q, c1_q, lft_q;

  assign up1_rd = up1_mem[col];
  assign up2_rd = up2_mem[col];
  assign cu1_rd = cu1_mem[col];

  always_ff @(posedge clk) begin
    if (accept) begin
      up2_mem[col] <= up1_rd;
      up1_mem[col] <= ref_px;
      cu1_mem[col] <= cur_px;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a1_q  <= '0;
      a2_q  <= '0;
      b1_q  <= '0;
      c1_q  <= '0;
      lft_q <= '0;
    end else if (accept) begin
      a1_q  <= up1_rd;
      a2_q  <= a1_q;
      b1_q  <= up2_rd;
      c1_q  <= cu1_rd;
      lft_q <= ref_px;
    end
  end

  // Centre sits one row up and one column left of the arriving pixel.
  assign gx = $signed({1'b0, up1_rd}) - $signed({1'b0, a2_q});
  assign gy = $signed({1'b0, lft_q})  - $signed({1'b0, b1_q});
  assign gt = $signed({1'b0, c1_q})   - $signed({1'b0, a1_q});
endmodule

// File: rtl/gsa_accum.sv
module gsa_accum
  import gsa_pkg::*;
#(
  parameter int unsigned DER_W = 9,
  parameter int unsigned ACC_W = 40,
  localparam int unsigned PRD_W = 2 * DER_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clr,
  input  logic                            en,
  input  logic signed [DER_W-1:0]         gx,
  input  logic signed [DER_W-1:0]         gy,
  input  logic signed [DER_W-1:0]         gt,
  output logic [N_SUMS-1:0][ACC_W-1:0]    sums
);
  logic signed [DER_W-1:0] opa [N_SUMS];
  logic signed [DER_W-1:0] opb [N_SUMS];
  logic [ACC_W-1:0] acc_q [N_SUMS];
  logic [ACC_W-1:0] acc_n [N_SUMS];

  // Order: xx, xy, yy, xt, yt
  always_comb begin
    opa[0] = gx; opb[0] = gx;
    opa[1] = gx; opb[1] = gy;
    opa[2] = gy; opb[2] = gy;
    opa[3] = gx; opb[3] = gt;
    opa[4] = gy; opb[4] = gt;
  end

  for (genvar k = 0; k < N_SUMS; k++) begin : g_lane
    logic signed [PRD_W-1:0] prod;
    assign prod = opa[k] * opb[k];

    always_comb begin
      acc_n[k] = acc_q[k];
      if (clr)     acc_n[k] = '0;
      else if (en) acc_n[k] = acc_q[k] + {{(ACC_W-PRD_W){prod[PRD_W-1]}}, prod};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q[k] <= '0;
      else        acc_q[k] <= acc_n[k];
    end

    assign sums[k] = acc_q[k];

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !en) |=> $stable(acc_q[k]));
    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc_q[k] == '0));
  end

  p_squares_nonneg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_q[0][ACC_W-1] && !acc_q[2][ACC_W-1]);
endmodule

// File: rtl/gsa_tracker.sv
module gsa_tracker
  import gsa_pkg::*;
#(
  parameter int unsigned PIX_W   = 8,
  parameter int unsigned MAX_DIM = 64,
  parameter int unsigned ACC_W   = 40,
  localparam int unsigned DIM_W  = $clog2(MAX_DIM + 1),
  localparam int unsigned COL_W  = $clog2(MAX_DIM),
  localparam int unsigned DER_W  = PIX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIM_W-1:0] win_w,
  input  logic [DIM_W-1:0] win_h,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] ref_px,
  input  logic [PIX_W-1:0] cur_px,
  output logic             done,
  output logic [ACC_W-1:0] sum_xx,
  output logic [ACC_W-1:0] sum_xy,
  output logic [ACC_W-1:0] sum_yy,
  output logic [ACC_W-1:0] sum_xt,
  output logic [ACC_W-1:0] sum_yt
);
  logic             accept, inner, last_px;
  logic [COL_W-1:0] col;
  logic signed [DER_W-1:0] gx, gy, gt;
  logic                    s1v_q, s1v_n, s1l_q, s1l_n;
  logic signed [DER_W-1:0] s1x_q, s1x_n, s1y_q, s1y_n, s1t_q, s1t_n;
  logic [N_SUMS-1:0][ACC_W-1:0] sums;

  gsa_win_ctrl #(.MAX_DIM(MAX_DIM)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .w_in(win_w), .h_in(win_h),
    .in_valid(in_valid), .tail_last(s1l_q), .in_ready(in_ready),
    .accept(accept), .inner(inner), .last_px(last_px), .col(col), .done(done)
  );

  gsa_line_taps #(.PIX_W(PIX_W), .MAX_DIM(MAX_DIM)) i_taps (
    .clk(clk), .rst_n(rst_n), .accept(accept), .col(col),
    .ref_px(ref_px), .cur_px(cur_px), .gx(gx), .gy(gy), .gt(gt)
  );

  // Derivative stage register between taps and accumulators.
  always_comb begin
    s1v_n = 1'b0;
    s1l_n = 1'b0;
    s1x_n = s1x_q;
    s1y_n = s1y_q;
    s1t_n = s1t_q;
    if (!start && accept) begin
      s1v_n = inner;
      s1l_n = last_px;
      s1x_n = gx;
      s1y_n = gy;
      s1t_n = gt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1v_q <= 1'b0;
      s1l_q <= 1'b0;
      s1x_q <= '0;
      s1y_q <= '0;
      s1t_q <= '0;
    end else begin
      s1v_q <= s1v_n;
      s1l_q <= s1l_n;
      s1x_q <= s1x_n;
      s1y_q <= s1y_n;
      s1t_q <= s1t_n;
    end
  end

  gsa_accum #(.DER_W(DER_W), .ACC_W(ACC_W)) i_acc (
    .clk(clk), .rst_n(rst_n), .clr(start), .en(s1v_q),
    .gx(s1x_q), .gy(s1y_q), .gt(s1t_q), .sums(sums)
  );

  assign sum_xx = sums[0];
  assign sum_xy = sums[1];
  assign sum_yy = sums[2];
  assign sum_xt = sums[3];
  assign sum_yt = sums[4];

  p_start_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!s1v_q && !s1l_q));
endmodule

// File: tb/test_gsa_tracker.sv
`timescale 1ns/1ps
module test_gsa_tracker;
  logic clk = 1'b0;
  logic rst_n;
  logic start, in_valid, in_ready, done;
  logic [6:0] win_w, win_h;
  logic [7:0] ref_px, cur_px;
  logic signed [39:0] s_xx, s_xy, s_yy, s_xt, s_yt;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  int ref_img [64][64];
  int cur_img [64][64];

  // Behavioural model state
  bit    m_busy = 0;
  int    m_dly = 0, m_cnt = 0, m_tot = 0;
  bit    m_res = 0;
  longint e_xx, e_xy, e_yy, e_xt, e_yt;
  string g_tag = "";

  always #2 clk = ~clk;

  gsa_tracker i_gsa_tracker (
    .clk(clk), .rst_n(rst_n), .start(start), .win_w(win_w), .win_h(win_h),
    .in_valid(in_valid), .in_ready(in_ready), .ref_px(ref_px), .cur_px(cur_px),
    .done(done), .sum_xx(s_xx), .sum_xy(s_xy), .sum_yy(s_yy),
    .sum_xt(s_xt), .sum_yt(s_yt)
  );

  task automatic chk(string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic chk_sums(string tag, bit zero);
    chk({tag, " sum_xx"}, longint'(s_xx), zero ? 0 : e_xx);
    chk({tag, " sum_xy"}, longint'(s_xy), zero ? 0 : e_xy);
    chk({tag, " sum_yy"}, longint'(s_yy), zero ? 0 : e_yy);
    chk({tag, " sum_xt"}, longint'(s_xt), zero ? 0 : e_xt);
    chk({tag, " sum_yt"}, longint'(s_yt), zero ? 0 : e_yt);
  endtask

  function automatic int clampd(int d);
    return (d > 64) ? 64 : d;
  endfunction

  function automatic void expect_for(int w0, int h0);
    int w = clampd(w0);
    int h = clampd(h0);
    e_xx = 0; e_xy = 0; e_yy = 0; e_xt = 0; e_yt = 0;
    for (int y = 1; y <= h - 2; y++)
      for (int x = 1; x <= w - 2; x++) begin
        longint ix = ref_img[y][x+1] - ref_img[y][x-1];
        longint iy = ref_img[y+1][x] - ref_img[y-1][x];
        longint it = cur_img[y][x] - ref_img[y][x];
        e_xx += ix * ix; e_xy += ix * iy; e_yy += iy * iy;
        e_xt += ix * it; e_yt += iy * it;
      end
  endfunction

  function automatic void fill(int mode);
    for (int y = 0; y < 64; y++)
      for (int x = 0; x < 64; x++) begin
        case (mode)
          0: begin ref_img[y][x] = $urandom % 256; cur_img[y][x] = $urandom % 256; end
          1: begin ref_img[y][x] = ($urandom % 2) ? 255 : 0; cur_img[y][x] = ($urandom % 2) ? 255 : 0; end
          2: begin ref_img[y][x] = (x * 9 + y * 5) % 256; cur_img[y][x] = ref_img[y][x]; end
          default: begin ref_img[y][x] = (x * 11) % 256; cur_img[y][x] = (x * 11 + 3) % 256; end
        endcase
      end
  endfunction

  // One clock: drive at the falling edge, check ready, advance model, check after rising edge.
  task automatic cycle(bit st, int w, int h, bit v, int rp, int cp, output bit acc);
    bit edone;
    @(negedge clk);
    start = st; win_w = 7'(w); win_h = 7'(h); in_valid = v;
    ref_px = 8'(rp); cur_px = 8'(cp);
    #1;
    chk("R3 in_ready", longint'(in_ready), longint'(m_busy && !st));
    acc = v && m_busy && !st;
    if (st) begin
      bit empty = (w == 0) || (h == 0);
      m_busy = !empty;
      edone = empty;
      m_dly = 0; m_cnt = 0;
      m_tot = clampd(w) * clampd(h);
      m_res = empty;
    end else begin
      edone = (m_dly == 1);
      if (m_dly > 0) m_dly--;
      if (acc) begin
        m_cnt++;
        if (m_cnt == m_tot) begin m_busy = 0; m_dly = 2; end
      end
      if (edone) m_res = 1;
    end
    @(posedge clk); #1;
    chk("R7 done", longint'(done), longint'(edone));
    if (st) chk_sums("R2 cleared on start", 1);
    else if (edone) chk_sums({g_tag, " R6 final"}, 0);
    else if (m_res && !m_busy) chk_sums({g_tag, " R8 held"}, 0);
  endtask

  task automatic open_win(int w, int h, bit v);
    bit a;
    expect_for(w, h);
    cycle(1, w, h, v, 7, 9, a);
  endtask

  task automatic send_pixels(int w0, int h0, int gap_pct, int limit);
    int w = clampd(w0);
    int h = clampd(h0);
    int n = 0;
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++) begin
        bit a = 0;
        if (n >= limit) return;
        while (gap_pct > 0 && ($urandom % 100) < gap_pct)
          cycle(0, 0, 0, 0, $urandom % 256, $urandom % 256, a);
        cycle(0, 0, 0, 1, ref_img[y][x], cur_img[y][x], a);
        if (!a) chk("R3 pixel accepted while open", 0, 1);
        n++;
      end
  endtask

  task automatic idle(int n);
    bit a;
    for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 0, 0, a);
  endtask

  task automatic run(string tag, int w, int h, int gap);
    g_tag = tag;
    open_win(w, h, 0);
    send_pixels(w, h, gap, 1 << 30);
    idle(5);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start = 0; in_valid = 0; win_w = 0; win_h = 0; ref_px = 0; cur_px = 0;
    repeat (3) @(negedge clk);
    chk("R1 in_ready in reset", longint'(in_ready), 0);
    chk("R1 done in reset", longint'(done), 0);
    e_xx = 0; e_xy = 0; e_yy = 0; e_xt = 0; e_yt = 0;
    chk_sums("R1 reset", 1);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk("R1 in_ready after reset", longint'(in_ready), 0);

    fill(0); run("R4 R5 small 5x4", 5, 4, 0);
    fill(2); run("R4 zero temporal", 9, 7, 0);
    fill(3); run("R5 no vertical gradient", 10, 6, 0);
    fill(0); run("R9 gapped 16x12", 16, 12, 40);
    fill(1); run("R6 extremes 64x64", 64, 64, 0);
    fill(0); run("R6 minimal 3x3", 3, 3, 0);
    fill(0); run("R6 no interior 2x5", 2, 5, 0);
    run("R10 zero width", 0, 5, 0);
    run("R10 zero height", 7, 0, 0);
    fill(0); run("R11 clamp 100x3", 100, 3, 10);

    // Restart mid-window with a pixel offered in the start cycle.
    fill(0);
    g_tag = "R12 abandoned";
    open_win(8, 8, 0);
    send_pixels(8, 8, 0, 21);
    fill(0);
    g_tag = "R12 restart 6x5";
    open_win(6, 5, 1);
    send_pixels(6, 5, 20, 1 << 30);
    idle(5);

    // Zero-size starts back to back.
    run("R10 repeat empty", 0, 0, 0);
    run("R10 repeat empty", 0, 3, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule